// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block is the hazard control for a five-stage integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the source register numbers of the instruction in decode. It compares them with the destinations of the two older instructions that sit in the decode/execute and execute/memory pipeline registers. From that comparison it decides two things. The first is where each ALU operand of that instruction must come from once it reaches execute. The second is whether the instruction must wait one cycle behind a load.

The operand selects are computed one stage early and registered, so they appear together with the instruction when it enters execute. A producer in decode/execute now will sit in execute/memory next cycle, and is chosen with the "from execute/memory" select. A producer in execute/memory now will sit in memory/write-back next cycle, and is chosen with the "from memory/write-back" select. A producer that is already in write-back needs no bypass, because the register file writes in the first half of a cycle and reads in the second half.

The stall output freezes the program counter and the fetch/decode register. During a stall the registered selects are loaded with the register-file code, which matches the no-op bubble that the pipeline puts into decode/execute. Producers are described by an instruction class and by their raw rt and rd fields, and the block works out for itself which field, if any, is written.

Top module: `bypass_interlock`

## Requirements
- R1: After reset, sel_a and sel_b both read 0 (register-file operand).
- R2: Select codes are 0 = register file, 1 = execute/memory result, 2 = memory/write-back result. If the decode/execute producer writes a register that equals a valid decode source, that operand's select is 1 in the cycle after the clock edge.
- R3: If only the execute/memory producer writes a register that equals a valid decode source, that operand's select is 2 in the cycle after the clock edge.
- R4: If both producers write the same register as a source, the select is 1 (the younger result wins).
- R5: stall is high in the same cycle when the decode/execute producer is a load whose destination equals a valid rs or rt source of the decode instruction.
- R6: In the cycle after a stall, sel_a and sel_b are both 0, even if a forwarding match existed.
- R7: A load in execute/memory matching a source does not stall, and gives select 2.
- R8: A source that no decode/execute or execute/memory producer writes gets select 0.
- R9: Class codes are 0 no-op, 1 register-register ALU, 2 immediate ALU, 3 load, 4 store, 5 branch. Class 1 writes its rd field, classes 2 and 3 write their rt field, and a match on the field that is not written has no effect.
- R10: Register 0 never causes forwarding or a stall.
- R11: Stores, branches and no-ops never act as producers. The rt source of a store in decode, when marked valid, is checked like any other source.
- R12: A source whose valid flag is low never causes forwarding or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rs_vld | input | 1 | First source is used |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| id_rt_vld | input | 1 | Second source is used |
| idex_cls | input | 3 | Class of the instruction in decode/execute |
| idex_rt | input | REG_AW | rt field of the instruction in decode/execute |
| idex_rd | input | REG_AW | rd field of the instruction in decode/execute |
| exmem_cls | input | 3 | Class of the instruction in execute/memory |
| exmem_rt | input | REG_AW | rt field of the instruction in execute/memory |
| exmem_rd | input | REG_AW | rd field of the instruction in execute/memory |
| stall | output | 1 | Hold PC and fetch/decode, insert a bubble |
| sel_a | output | 2 | Registered select for ALU operand A (rs) |
| sel_b | output | 2 | Registered select for ALU operand B (rt) |

## Verification
The assertions assume that class inputs hold only the six defined codes. They also assume that the pipeline state shown at the ports is consistent from cycle to cycle, so that what was in decode/execute in one cycle is in execute/memory in the next. The bench drives each scenario for a single clock. Each scenario sets up producers whose classes are legal and whose register fields are chosen to hit or miss exactly the match under test. The bench checks stall in the cycle where the inputs are applied and the selects just after the following edge. Checker properties that depend on a previous cycle only look at the registered selects and at the inputs that were sampled on that edge.

// File: rtl/bypass_interlock_pkg.sv
package bypass_interlock_pkg;

   typedef enum logic [2:0] {
      CLS_NOP    = 3'd0,
      CLS_ALU_RR = 3'd1,
      CLS_ALU_IM = 3'd2,
      CLS_LOAD   = 3'd3,
      CLS_STORE  = 3'd4,
      CLS_BRANCH = 3'd5
   } instr_cls_e;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_RF    = 2'd0,
      SEL_EXMEM = 2'd1,
      SEL_MEMWB = 2'd2
   } opnd_sel_e;

   localparam int NUM_OPND = 2;

endpackage

// File: rtl/bypass_dest_decode.sv
module bypass_dest_decode
   import bypass_interlock_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic [2:0]        cls,
   input  logic [REG_AW-1:0] rt,
   input  logic [REG_AW-1:0] rd,
   output logic              wr,
   output logic              is_load,
   output logic [REG_AW-1:0] dest
);
   always_comb begin
      wr      = 1'b0;
      is_load = 1'b0;
      dest    = '0;
      case (instr_cls_e'(cls))
         CLS_ALU_RR: begin wr = 1'b1; dest = rd; end
         CLS_ALU_IM: begin wr = 1'b1; dest = rt; end
         CLS_LOAD:   begin wr = 1'b1; dest = rt; is_load = 1'b1; end
         default:    begin wr = 1'b0; end
      endcase
      if (dest == '0) wr = 1'b0;
   end
endmodule

// File: rtl/bypass_operand_match.sv
module bypass_operand_match
   import bypass_interlock_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic              src_vld,
   input  logic              near_wr,
   input  logic [REG_AW-1:0] near_dest,
   input  logic              far_wr,
   input  logic [REG_AW-1:0] far_dest,
   input  logic              hold,
   output logic [SEL_W-1:0]  nxt_sel
);
   logic live;
   logic hit_near;
   logic hit_far;

   assign live     = src_vld && (src != '0);
   assign hit_near = live && near_wr && (near_dest == src);
   assign hit_far  = live && far_wr  && (far_dest  == src);

   always_comb begin
      if (hold)          nxt_sel = SEL_RF;
      else if (hit_near) nxt_sel = SEL_EXMEM;
      else if (hit_far)  nxt_sel = SEL_MEMWB;
      else               nxt_sel = SEL_RF;
   end
endmodule

// File: rtl/bypass_load_use.sv
module bypass_load_use #(
   parameter int REG_AW   = 5,
   parameter int NUM_SRC  = 2
) (
   input  logic [REG_AW-1:0] src     [NUM_SRC],
   input  logic              src_vld [NUM_SRC],
   input  logic              ld_wr,
   input  logic              ld_is_load,
   input  logic [REG_AW-1:0] ld_dest,
   output logic              stall
);
   logic [NUM_SRC-1:0] dep;

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_dep
      assign dep[k] = src_vld[k] && (src[k] != '0) && (src[k] == ld_dest);
   end

   assign stall = ld_wr && ld_is_load && (|dep);
endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
   import bypass_interlock_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs,
   input  logic              id_rs_vld,
   input  logic [REG_AW-1:0] id_rt,
   input  logic              id_rt_vld,
   input  logic [2:0]        idex_cls,
   input  logic [REG_AW-1:0] idex_rt,
   input  logic [REG_AW-1:0] idex_rd,
   input  logic [2:0]        exmem_cls,
   input  logic [REG_AW-1:0] exmem_rt,
   input  logic [REG_AW-1:0] exmem_rd,
   output logic              stall,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b
);
   if (REG_AW < 2 || REG_AW > 8) begin : g_bad_aw
      $error("bypass_interlock: REG_AW must lie in 2..8");
   end

   logic              near_wr, near_ld, far_wr, far_ld;
   logic [REG_AW-1:0] near_dest, far_dest;

   bypass_dest_decode #(.REG_AW(REG_AW)) u_near (
      .cls(idex_cls), .rt(idex_rt), .rd(idex_rd),
      .wr(near_wr), .is_load(near_ld), .dest(near_dest));

   bypass_dest_decode #(.REG_AW(REG_AW)) u_far (
      .cls(exmem_cls), .rt(exmem_rt), .rd(exmem_rd),
      .wr(far_wr), .is_load(far_ld), .dest(far_dest));

   logic [REG_AW-1:0] src     [NUM_OPND];
   logic              src_vld [NUM_OPND];
   logic [SEL_W-1:0]  nxt_sel [NUM_OPND];
   logic [SEL_W-1:0]  sel_q   [NUM_OPND];
   logic              hazard;

   assign src[0]     = id_rs;
   assign src[1]     = id_rt;
   assign src_vld[0] = id_rs_vld;
   assign src_vld[1] = id_rt_vld;

   bypass_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_OPND)) u_lu (
      .src(src), .src_vld(src_vld),
      .ld_wr(near_wr), .ld_is_load(near_ld), .ld_dest(near_dest),
      .stall(hazard));

   for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
      bypass_operand_match #(.REG_AW(REG_AW)) u_match (
         .src(src[k]), .src_vld(src_vld[k]),
         .near_wr(near_wr), .near_dest(near_dest),
         .far_wr(far_wr), .far_dest(far_dest),
         .hold(hazard), .nxt_sel(nxt_sel[k]));

      always_ff @(posedge clk) begin
         if (!rst_n) sel_q[k] <= SEL_RF;
         else        sel_q[k] <= nxt_sel[k];
      end
   end

   logic unused_far_ld;
   assign unused_far_ld = far_ld;

   assign stall = hazard;
   assign sel_a = sel_q[0];
   assign sel_b = sel_q[1];
endmodule

// File: rtl/bypass_interlock_chk.sv
module bypass_interlock_chk #(
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] id_rs,
   input logic              id_rs_vld,
   input logic [REG_AW-1:0] id_rt,
   input logic              id_rt_vld,
   input logic [2:0]        idex_cls,
   input logic [REG_AW-1:0] idex_rt,
   input logic              stall,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b
);
   // R1: selects are register-file while in reset
   p_reset_sel_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (sel_a == 2'd0 && sel_b == 2'd0));

   // R6: bubble after stall
   p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stall) |-> (sel_a == 2'd0 && sel_b == 2'd0));

   // R10: register 0 never forwarded
   p_no_zero_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a != 2'd0) |-> ($past(id_rs) != '0));
   p_no_zero_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b != 2'd0) |-> ($past(id_rt) != '0));

   // R12: invalid sources never forwarded
   p_invalid_a_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a != 2'd0) |-> $past(id_rs_vld));
   p_invalid_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b != 2'd0) |-> $past(id_rt_vld));

   // R11: stores, branches and no-ops in decode/execute never cause a stall
   p_nonprod_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_cls == 3'd0 || idex_cls == 3'd4 || idex_cls == 3'd5) |-> !stall);

   // R5: load-use stall on rs
   p_load_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_cls == 3'd3 && id_rs_vld && id_rs != '0 && id_rs == idex_rt) |-> stall);

   // R2: legal select codes only
   p_legal_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a != 2'd3 && sel_b != 2'd3));
endmodule

bind bypass_interlock bypass_interlock_chk #(.REG_AW(REG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .id_rs(id_rs), .id_rs_vld(id_rs_vld), .id_rt(id_rt), .id_rt_vld(id_rt_vld),
   .idex_cls(idex_cls), .idex_rt(idex_rt),
   .stall(stall), .sel_a(sel_a), .sel_b(sel_b));

// File: tb/tb_bypass_interlock.sv
module tb_bypass_interlock;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] id_rs = '0, id_rt = '0;
   logic          id_rs_vld = 1'b0, id_rt_vld = 1'b0;
   logic [2:0]    idex_cls = 3'd0, exmem_cls = 3'd0;
   logic [AW-1:0] idex_rt = '0, idex_rd = '0, exmem_rt = '0, exmem_rd = '0;
   logic          stall;
   logic [1:0]    sel_a, sel_b;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   bypass_interlock #(.REG_AW(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .id_rs(id_rs), .id_rs_vld(id_rs_vld), .id_rt(id_rt), .id_rt_vld(id_rt_vld),
      .idex_cls(idex_cls), .idex_rt(idex_rt), .idex_rd(idex_rd),
      .exmem_cls(exmem_cls), .exmem_rt(exmem_rt), .exmem_rd(exmem_rd),
      .stall(stall), .sel_a(sel_a), .sel_b(sel_b));

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Apply one cycle of pipeline state at negedge, check stall, then selects after the edge.
   task automatic cyc(input string tag,
                      input int rs, input int rsv, input int rt, input int rtv,
                      input int ec, input int ert, input int erd,
                      input int mc, input int mrt, input int mrd,
                      input int exp_stall, input int exp_a, input int exp_b);
      @(negedge clk);
      id_rs = AW'(rs); id_rs_vld = rsv[0]; id_rt = AW'(rt); id_rt_vld = rtv[0];
      idex_cls = 3'(ec); idex_rt = AW'(ert); idex_rd = AW'(erd);
      exmem_cls = 3'(mc); exmem_rt = AW'(mrt); exmem_rd = AW'(mrd);
      #1;
      chk({tag, " stall"}, int'(stall), exp_stall);
      @(posedge clk);
      #1;
      chk({tag, " sel_a"}, int'(sel_a), exp_a);
      chk({tag, " sel_b"}, int'(sel_b), exp_b);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 reset sel_a", int'(sel_a), 0);
      chk("R1 reset sel_b", int'(sel_b), 0);
   endtask

   task automatic t_near();
      cyc("R2 rr rd->rs", 7, 1, 9, 1, 1, 2, 7, 0, 0, 0, 0, 1, 0);
      cyc("R2 imm rt->rt", 4, 1, 9, 1, 2, 9, 3, 0, 0, 0, 0, 0, 1);
   endtask

   task automatic t_far();
      cyc("R3 far rs", 6, 1, 8, 1, 0, 0, 0, 1, 1, 6, 0, 2, 0);
      cyc("R8 no producer", 11, 1, 12, 1, 1, 0, 13, 2, 14, 0, 0, 0, 0);
   endtask

   task automatic t_priority();
      cyc("R4 both match", 5, 1, 5, 1, 1, 0, 5, 2, 5, 0, 0, 1, 1);
   endtask

   task automatic t_load_use();
      cyc("R5 load rs stall", 3, 1, 10, 1, 3, 3, 0, 0, 0, 0, 1, 0, 0);
      cyc("R6 after stall", 3, 1, 10, 1, 0, 0, 0, 3, 3, 0, 0, 2, 0);
      cyc("R5 load rt stall", 1, 1, 8, 1, 3, 8, 0, 0, 0, 0, 1, 0, 0);
   endtask

   task automatic t_load_far();
      cyc("R7 load far", 15, 1, 16, 1, 0, 0, 0, 3, 16, 0, 0, 0, 2);
   endtask

   task automatic t_field();
      cyc("R9 rr rt ignored", 20, 1, 21, 1, 1, 20, 22, 0, 0, 0, 0, 0, 0);
      cyc("R9 imm rd ignored", 20, 1, 21, 1, 2, 23, 20, 3, 24, 21, 0, 0, 0);
      cyc("R9 load rd ignored", 17, 1, 18, 1, 3, 19, 17, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_zero();
      cyc("R10 r0 near", 0, 1, 0, 1, 1, 0, 0, 2, 0, 0, 0, 0, 0);
      cyc("R10 r0 load", 0, 1, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_nonprod();
      cyc("R11 store near", 25, 1, 26, 1, 4, 25, 26, 5, 25, 26, 0, 0, 0);
      cyc("R11 nop far", 25, 1, 26, 1, 0, 25, 25, 4, 26, 26, 0, 0, 0);
      cyc("R11 store rt src", 2, 1, 27, 1, 3, 27, 0, 0, 0, 0, 1, 0, 0);
   endtask

   task automatic t_invalid();
      cyc("R12 invalid near", 28, 0, 29, 0, 1, 0, 28, 2, 29, 0, 0, 0, 0);
      cyc("R12 invalid load", 30, 0, 31, 0, 3, 30, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_near();
      t_far();
      t_priority();
      t_load_use();
      t_load_far();
      t_field();
      t_zero();
      t_nonprod();
      t_invalid();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule